// File: doc/BRIEF.md
# UART Receive FIFO Interrupt Controller

This block produces the receive-side interrupt and status signals for a UART whose receive FIFO holds up to 16 characters. It observes the FIFO from outside: its occupancy count, a strobe for each character that the serial shifter writes in, and a strobe for each host read. From these it derives a data-ready status bit, a data-available interrupt that follows a programmable fill threshold, and a character timeout interrupt. The timeout interrupt flags characters that are left in the FIFO while the line and the host are both idle.

Idle time is counted in character times. A character time is sixteen ticks of the receiver reference clock per bit. The bit count is the start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits. The timeout therefore scales with the baud rate and with the frame format. A four-bit interrupt code combines the pending conditions in priority order, with a line-status error on top.

The FIFO storage, the serial shifter and the baud generator live outside this block.

Top module: `rx_fifo_irq`

## Requirements
- R1: `rda_irq` and `to_irq` are 0 unless `fifo_en` and `rda_en` are both 1. Clearing either enable does not disturb the fill comparison or the idle timer.
- R2: `rda_irq` equals `fifo_en & rda_en & (fill >= L)` in the same cycle. L is 1, 4, 8 or 14 for `trig_sel` values 0, 1, 2 and 3.
- R3: `intr_code` is 4'h6 when `line_err & ls_en` is 1. Otherwise it is 4'hC when `to_irq` is 1, then 4'h4 when `rda_irq` is 1, and 4'h1 when nothing is pending.
- R4: `data_ready` is 1 in the cycle after any cycle with `push` high. It is 0 in the cycle after a cycle with `fill` = 0 and `push` low. Otherwise it keeps its value.
- R5: A restart happens in any cycle where `push`, `pop` or `fill` = 0 holds. `to_irq` (when enabled) rises after the clock edge that samples the 64·B-th `ref_tick` since the last restart, as long as `fill` stays nonzero.
- R6: B = 1 + (5 + `data_len`) + `parity_en` + (1 + `two_stop`). The parity bit and the second stop bit each lengthen the timeout by 64 ticks.
- R7: A cycle with `pop` high clears a fired timeout, so `to_irq` is 0 in the next cycle, and restarts the idle count.
- R8: Before a timeout has fired, `push` or `pop` restarts the count, even in the cycle of the final tick. After it has fired, `push` alone does not clear it.
- R9: A cycle with `fill` = 0 clears a fired timeout and restarts the idle count.
- R10: While reset is held and after its release, `data_ready`, `rda_irq` and `to_irq` are 0, and `intr_code` is 4'h1 while no input requests an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| rda_en | input | 1 | Receive-data interrupt enable |
| ls_en | input | 1 | Line-status interrupt enable |
| fill | input | 5 | Current FIFO occupancy, 0 to 16 |
| push | input | 1 | A character entered the FIFO this cycle |
| pop | input | 1 | The host read the FIFO this cycle |
| trig_sel | input | 2 | Fill threshold select |
| line_err | input | 1 | Receiver line error pending |
| data_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Second stop bit present |
| ref_tick | input | 1 | One reference-clock tick (16 per bit) |
| data_ready | output | 1 | Receive data present |
| rda_irq | output | 1 | Data-available interrupt |
| to_irq | output | 1 | Character timeout interrupt |
| intr_code | output | 4 | Prioritised interrupt code |

## Verification
The idle timer's expiry and its restart can land on the same clock edge. A push or pop that coincides with the final tick must win, and a push that arrives after expiry must not cancel the interrupt. The bench places a push exactly on the 64·B-th tick and checks that `to_irq` stays low for another full window. It also checks that a later push leaves a fired timeout standing while a pop clears it. A second overlap is a line error arriving while a timeout or data-available interrupt is pending; random stimulus toggles `line_err` freely, and the per-cycle reference model judges the resulting code.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
  typedef logic [3:0] irq_code_t;

  localparam irq_code_t CODE_NONE = 4'h1;
  localparam irq_code_t CODE_LINE = 4'h6;
  localparam irq_code_t CODE_DATA = 4'h4;
  localparam irq_code_t CODE_IDLE = 4'hC;

  localparam int MAX_CHAR_BITS = 12;

  // start + 5 data + 1 stop = 7, then the optional extras
  function automatic logic [3:0] char_bits(input logic [1:0] dlen,
                                           input logic par,
                                           input logic two);
    return 4'd7 + {2'b00, dlen} + {3'b000, par} + {3'b000, two};
  endfunction
endpackage

// File: rtl/rxirq_level.sv
module rxirq_level #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] fill,
  input  logic          push,
  input  logic [1:0]    trig_sel,
  input  logic          gate,
  output logic          rda_irq,
  output logic          data_ready
);
  localparam int NLVL = 4;

  function automatic int lvl_of(input int idx);
    case (idx)
      0:       return 1;
      1:       return DEPTH / 4;
      2:       return DEPTH / 2;
      default: return DEPTH - 2;
    endcase
  endfunction

  logic [CW-1:0] lvl_tab [NLVL];

  for (genvar gi = 0; gi < NLVL; gi++) begin : g_lvl
    assign lvl_tab[gi] = CW'(lvl_of(gi));
  end

  logic dr_q, dr_d;

  always_comb begin
    rda_irq = gate & (fill >= lvl_tab[trig_sel]);
    dr_d    = push | (dr_q & (|fill));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dr_q <= 1'b0;
    else        dr_q <= dr_d;
  end

  assign data_ready = dr_q;
endmodule

// File: rtl/rxirq_idle_timer.sv
module rxirq_idle_timer #(
  parameter int OVS        = 16,
  parameter int IDLE_CHARS = 4,
  parameter int MAXB       = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       restart,
  input  logic       clear,
  input  logic [3:0] bits,
  output logic       expired
);
  localparam int SW  = $clog2(OVS * MAXB);
  localparam int CHW = $clog2(IDLE_CHARS + 1);

  logic [SW-1:0]  sub_q, sub_d, last;
  logic [CHW-1:0] chr_q, chr_d;
  logic           exp_q, exp_d;

  always_comb begin
    last  = SW'(OVS * int'(bits)) - SW'(1);
    sub_d = sub_q;
    chr_d = chr_q;
    exp_d = exp_q;
    if (clear) exp_d = 1'b0;
    if (restart) begin
      sub_d = '0;
      chr_d = '0;
    end else if (ref_tick && (chr_q != CHW'(IDLE_CHARS))) begin
      if (sub_q == last) begin
        sub_d = '0;
        chr_d = chr_q + CHW'(1);
        if (chr_q == CHW'(IDLE_CHARS - 1)) exp_d = 1'b1;
      end else begin
        sub_d = sub_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      chr_q <= '0;
      exp_q <= 1'b0;
    end else begin
      sub_q <= sub_d;
      chr_q <= chr_d;
      exp_q <= exp_d;
    end
  end

  assign expired = exp_q;
endmodule

// File: rtl/rxirq_id_enc.sv
module rxirq_id_enc
  import rxirq_pkg::*;
(
  input  logic      ls_req,
  input  logic      to_req,
  input  logic      rda_req,
  output irq_code_t code
);
  always_comb begin
    if (ls_req)       code = CODE_LINE;
    else if (to_req)  code = CODE_IDLE;
    else if (rda_req) code = CODE_DATA;
    else              code = CODE_NONE;
  end
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq
  import rxirq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int OVS        = 16,
  parameter int IDLE_CHARS = 4,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          rda_en,
  input  logic          ls_en,
  input  logic [CW-1:0] fill,
  input  logic          push,
  input  logic          pop,
  input  logic [1:0]    trig_sel,
  input  logic          line_err,
  input  logic [1:0]    data_len,
  input  logic          parity_en,
  input  logic          two_stop,
  input  logic          ref_tick,
  output logic          data_ready,
  output logic          rda_irq,
  output logic          to_irq,
  output logic [3:0]    intr_code
);
  logic gate, empty, restart, clear, expired, ls_req;
  logic [3:0] bits;

  always_comb begin
    gate    = fifo_en & rda_en;
    empty   = ~|fill;
    restart = push | pop | empty;
    clear   = pop | empty;
    bits    = char_bits(data_len, parity_en, two_stop);
    ls_req  = line_err & ls_en;
    to_irq  = expired & gate;
  end

  rxirq_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk(clk), .rst_n(rst_n), .fill(fill), .push(push),
    .trig_sel(trig_sel), .gate(gate),
    .rda_irq(rda_irq), .data_ready(data_ready)
  );

  rxirq_idle_timer #(.OVS(OVS), .IDLE_CHARS(IDLE_CHARS), .MAXB(MAX_CHAR_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .restart(restart),
    .clear(clear), .bits(bits), .expired(expired)
  );

  rxirq_id_enc u_enc (
    .ls_req(ls_req), .to_req(to_irq), .rda_req(rda_irq), .code(intr_code)
  );
endmodule

// File: rtl/rx_fifo_irq_chk.sv
module rx_fifo_irq_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          rda_en,
  input logic          ls_en,
  input logic [CW-1:0] fill,
  input logic          push,
  input logic          pop,
  input logic          line_err,
  input logic          data_ready,
  input logic          rda_irq,
  input logic          to_irq,
  input logic [3:0]    intr_code
);
  // R4
  dr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> data_ready);

  // R4
  dr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && fill == '0) |=> !data_ready);

  // R7
  to_pop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !to_irq);

  // R8
  to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_irq && !pop && fill != '0) |=> (to_irq || !fifo_en || !rda_en));

  // R8
  to_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(to_irq) && $stable(fifo_en) && $stable(rda_en)) |-> $past(!push && !pop));

  // R1
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_en && rda_en) |-> (!to_irq && !rda_irq));

  // R3
  ls_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err && ls_en) |-> (intr_code == 4'h6));

  // R3
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_code == 4'h1) |-> (!to_irq && !rda_irq && !(line_err && ls_en)));
endmodule

bind rx_fifo_irq rx_fifo_irq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rda_en(rda_en), .ls_en(ls_en),
  .fill(fill), .push(push), .pop(pop), .line_err(line_err),
  .data_ready(data_ready), .rda_irq(rda_irq), .to_irq(to_irq), .intr_code(intr_code)
);

// File: tb/sim_rx_fifo_irq.sv
module sim_rx_fifo_irq;
  logic clk, rst_n;
  logic fifo_en, rda_en, ls_en, push, pop, line_err, parity_en, two_stop, ref_tick;
  logic [4:0] fill;
  logic [1:0] trig_sel, data_len;
  logic data_ready, rda_irq, to_irq;
  logic [3:0] intr_code;

  int tests = 0;
  int fails = 0;

  rx_fifo_irq u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rda_en(rda_en), .ls_en(ls_en),
    .fill(fill), .push(push), .pop(pop), .trig_sel(trig_sel), .line_err(line_err),
    .data_len(data_len), .parity_en(parity_en), .two_stop(two_stop), .ref_tick(ref_tick),
    .data_ready(data_ready), .rda_irq(rda_irq), .to_irq(to_irq), .intr_code(intr_code)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int level_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int window(input logic [1:0] dl, input logic p, input logic t);
    return 64 * (1 + 5 + int'(dl) + int'(p) + 1 + int'(t));
  endfunction

  function automatic logic [3:0] code_of(input logic ls, input logic to, input logic rd);
    if (ls) return 4'h6;
    if (to) return 4'hC;
    if (rd) return 4'h4;
    return 4'h1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on each clock edge
  int   m_idle;
  logic m_to, m_dr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idle <= 0; m_to <= 1'b0; m_dr <= 1'b0;
    end else begin
      m_dr <= push | (m_dr & (fill != 0));
      if (pop || fill == 0) m_to <= 1'b0;
      if (push || pop || fill == 0) m_idle <= 0;
      else if (ref_tick && m_idle < window(data_len, parity_en, two_stop)) begin
        m_idle <= m_idle + 1;
        if (m_idle + 1 == window(data_len, parity_en, two_stop)) m_to <= 1'b1;
      end
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic g, e_rd, e_to;
      g    = fifo_en & rda_en;
      e_rd = g & (int'(fill) >= level_of(trig_sel));
      e_to = g & m_to;
      chk("R2 rda_irq", rda_irq, e_rd);
      chk("R5 R7 R8 R9 to_irq", to_irq, e_to);
      chk("R4 data_ready", data_ready, m_dr);
      chk("R3 intr_code", intr_code, code_of(line_err & ls_en, e_to, e_rd));
    end
  end

  task automatic start_idle(input logic [1:0] dl, input logic p, input logic t);
    @(negedge clk);
    data_len = dl; parity_en = p; two_stop = t;
    fill = 5'd1; push = 1'b1; pop = 1'b0; ref_tick = 1'b1;
    @(negedge clk);
    push = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int w;
    process::self().srandom(32'd1234);
    rst_n = 1'b0; fifo_en = 1'b1; rda_en = 1'b1; ls_en = 1'b1; push = 1'b0; pop = 1'b0;
    line_err = 1'b0; parity_en = 1'b0; two_stop = 1'b0; ref_tick = 1'b0;
    fill = 5'd0; trig_sel = 2'd0; data_len = 2'd3;
    repeat (3) @(negedge clk);
    chk("R10 data_ready in reset", data_ready, 0);
    chk("R10 code in reset", intr_code, 4'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rda_irq after reset", rda_irq, 0);
    chk("R10 to_irq after reset", to_irq, 0);
    chk("R10 code after reset", intr_code, 4'h1);

    // R2 threshold boundaries
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      fill = 5'(level_of(2'(s)) - 1);
      #1 chk("R2 below level", rda_irq, 0);
      @(negedge clk);
      fill = 5'(level_of(2'(s)));
      #1 chk("R2 at level", rda_irq, 1);
      chk("R3 data code", intr_code, 4'h4);
      @(negedge clk);
    end

    // R1 enables off
    fill = 5'd16; fifo_en = 1'b0;
    #1 chk("R1 fifo_en off", rda_irq, 0);
    @(negedge clk);
    fifo_en = 1'b1; rda_en = 1'b0;
    #1 chk("R1 rda_en off", rda_irq, 0);
    chk("R1 code idle", intr_code, 4'h1);
    @(negedge clk);
    rda_en = 1'b1; fill = 5'd0;
    @(negedge clk);

    // R5: exact window, 8N1 gives 640 ticks
    start_idle(2'd3, 1'b0, 1'b0);
    w = window(2'd3, 1'b0, 1'b0);
    repeat (w - 1) @(negedge clk);
    chk("R5 one tick early", to_irq, 0);
    @(negedge clk);
    chk("R5 fires on last tick", to_irq, 1);
    chk("R3 timeout code", intr_code, 4'hC);
    line_err = 1'b1;
    #1 chk("R3 line error over timeout", intr_code, 4'h6);
    line_err = 1'b0;
    // R8 push after expiry keeps it
    push = 1'b1;
    @(negedge clk);
    push = 1'b0;
    chk("R8 push keeps fired timeout", to_irq, 1);
    // R7 pop clears
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    chk("R7 pop clears", to_irq, 0);
    // restart by pop: a full window again
    repeat (w - 1) @(negedge clk);
    chk("R7 restart window early", to_irq, 0);
    @(negedge clk);
    chk("R7 refires after window", to_irq, 1);
    // R9 empty clears
    fill = 5'd0;
    @(negedge clk);
    chk("R9 empty clears timeout", to_irq, 0);
    chk("R9 empty clears data_ready", data_ready, 0);

    // R8 push on the final tick wins
    start_idle(2'd0, 1'b1, 1'b1);
    w = window(2'd0, 1'b1, 1'b1);
    repeat (w - 1) @(negedge clk);
    push = 1'b1;
    @(negedge clk);
    push = 1'b0;
    chk("R8 push on final tick", to_irq, 0);
    repeat (w - 1) @(negedge clk);
    chk("R8 new window early", to_irq, 0);
    @(negedge clk);
    chk("R8 new window fires", to_irq, 1);

    // R6 second stop bit adds 64 ticks
    fill = 5'd0;
    start_idle(2'd2, 1'b0, 1'b1);
    repeat (window(2'd2, 1'b0, 1'b0)) @(negedge clk);
    chk("R6 not yet with two stops", to_irq, 0);
    repeat (64) @(negedge clk);
    chk("R6 fires with two stops", to_irq, 1);
    fill = 5'd0;
    @(negedge clk);

    // constrained random phase, checked by the model each cycle
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      push = ($urandom_range(0, 1999) == 0);
      pop  = ($urandom_range(0, 1999) == 0);
      ref_tick = ($urandom_range(0, 9) < 8);
      if ($urandom_range(0, 49) == 0) line_err = ~line_err;
      if ($urandom_range(0, 1499) == 0) fill = 5'($urandom_range(0, 16));
      if ($urandom_range(0, 2999) == 0) begin
        fifo_en = ($urandom_range(0, 3) != 0);
        rda_en  = ($urandom_range(0, 3) != 0);
        ls_en   = $urandom_range(0, 1);
        trig_sel = 2'($urandom_range(0, 3));
      end
      if (push && $urandom_range(0, 3) == 0) begin
        data_len  = 2'($urandom_range(0, 3));
        parity_en = $urandom_range(0, 1);
        two_stop  = $urandom_range(0, 1);
      end
    end
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule